// File: doc/BRIEF.md
# Configurable Logic Cell

This block is a reconfigurable logic element built around one 64-bit storage array. The array can act as a single 6-input lookup table or as two 5-input lookup tables that share their inputs. It can also act as a 64x1 distributed RAM, as one 32-stage shift register with an addressable tap, or as two independent 16-stage shift registers. The current personality comes from a 3-bit mode register.

The six `sel` inputs address the array in every mode. In the RAM mode, `din[0]` and `we` write the array. In the shift modes, `din` and `sh_en` feed the chains. Two combinational outputs `o` show the selected bits, and the last stage of each chain comes out on `cas_o` so that cells can be chained. A pair of output flip-flops `q` can register `o`; they have a clock enable and a synchronous clear.

Mode and contents are written through a parallel load port that has two strobes. One strobe loads the mode and the other loads the contents, so either can change without disturbing the other.

Top module: `cfg_logic_cell`

## Requirements
- R1: On a rising edge with `init_ld` high the array takes `init_bits`. On a rising edge with `mode_ld` high and `rst` low the mode register takes `mode_in`. A load in a cycle blocks any RAM write or shift in that same cycle.
- R2: In mode code 0 (single 6-input table), `o[0]` equals array bit `sel` and `o[1]` is 0.
- R3: In mode code 1 (dual 5-input tables), `o[0]` equals bit `sel[4:0]` and `o[1]` equals bit `32+sel[4:0]`; `sel[5]` has no effect.
- R4: In mode code 2 (64x1 RAM), `o[0]` reads bit `sel` without waiting for a clock and `o[1]` is 0. A rising edge with `we` high stores `din[0]` into bit `sel` and leaves every other bit unchanged.
- R5: In mode code 3 (32-stage shift), a rising edge with `sh_en[0]` high moves bits 0..30 up by one and places `din[0]` at bit 0; bits 32..63 are untouched. `o[0]` equals bit `sel[4:0]`, `o[1]` is 0, and `cas_o` equals {0, bit 31}.
- R6: In mode code 4 (two 16-stage shifts), `sh_en[0]`/`din[0]` drive the chain in bits 0..15 and `sh_en[1]`/`din[1]` drive the chain in bits 16..31, each independently. `o` equals {bit `16+sel[3:0]`, bit `sel[3:0]`} and `cas_o` equals {bit 31, bit 15}.
- R7: `we` has no effect outside mode code 2, and `sh_en` has no effect outside mode codes 3 and 4.
- R8: Loading only the mode leaves all 64 stored bits unchanged.
- R9: On a rising edge `q` clears to 0 when `ff_srst` is high. Otherwise `q` takes `o` when `ff_ce` is high and holds when it is low.
- R10: A rising edge with `rst` high sets the mode to code 0 and clears `q`, and keeps the stored bits. Outside the shift modes `cas_o` is 0.
- R11: Mode codes 5, 6 and 7 behave as mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of mode register and output flops |
| init_ld | input | 1 | Strobe: load array contents |
| init_bits | input | 64 | Contents to load |
| mode_ld | input | 1 | Strobe: load mode register |
| mode_in | input | 3 | Mode code to load |
| sel | input | 6 | Address / lookup select inputs |
| din | input | 2 | Serial / write data (bit 1 feeds the upper 16-stage chain) |
| we | input | 1 | RAM write enable |
| sh_en | input | 2 | Shift enables (bit 1 for the upper 16-stage chain) |
| ff_ce | input | 1 | Output flop clock enable |
| ff_srst | input | 1 | Output flop synchronous clear |
| o | output | 2 | Combinational outputs |
| q | output | 2 | Registered outputs |
| cas_o | output | 2 | Last-stage cascade outputs |

## Verification
The bench pushes a marker bit through the full length of each chain, so that it shows on `cas_o` and then drops off the end. A chain that is one stage too long or too short, or that leaks into bits 32..63, would misplace the marker or corrupt the upper half. In the split mode the bench shifts one chain while the other stays idle; a cell that wired the two halves together would move the idle chain's bit. Several other stimuli go straight at the edge cases: a content load in the same cycle as a RAM write, a write or shift in the wrong mode, a mode-only load, and `sel[5]` toggling in dual-table mode. A design that let the write win over the load, honoured a stray enable, wiped the contents on a mode change, or decoded the top select bit would return a wrong `o`.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  typedef enum logic [2:0] {
    LC_LUT6    = 3'd0,
    LC_LUT5X2  = 3'd1,
    LC_RAM     = 3'd2,
    LC_SRL32   = 3'd3,
    LC_SRL16X2 = 3'd4
  } lc_mode_e;

  function automatic logic lc_is_shift(lc_mode_e m);
    return (m == LC_SRL32) || (m == LC_SRL16X2);
  endfunction

  function automatic logic lc_is_split(lc_mode_e m);
    return m == LC_SRL16X2;
  endfunction

endpackage

// File: rtl/lcell_ctrl.sv
module lcell_ctrl
  import lcell_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_ld,
  input  logic       init_ld,
  input  logic [2:0] mode_in,
  input  logic       we,
  input  logic [1:0] sh_en,
  output lc_mode_e   mode_q,
  output logic       ram_wr_evt,
  output logic       lo_shift_evt,
  output logic       hi_shift_evt
);

  logic any_ld;
  logic ops_ok;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= LC_LUT6;
    else if (mode_ld) mode_q <= lc_mode_e'(mode_in);
  end

  assign any_ld       = init_ld | mode_ld;
  assign ops_ok       = ~any_ld & ~rst;
  assign ram_wr_evt   = ops_ok & we & (mode_q == LC_RAM);
  assign lo_shift_evt = ops_ok & sh_en[0] & lc_is_shift(mode_q);
  assign hi_shift_evt = ops_ok & sh_en[1] & lc_is_split(mode_q);

endmodule

// File: rtl/lcell_store.sv
module lcell_store
  import lcell_pkg::*;
#(
  parameter int SEL_W = 6,
  localparam int DEPTH   = 1 << SEL_W,
  localparam int HALF    = DEPTH / 2,
  localparam int QUARTER = DEPTH / 4
) (
  input  logic             clk,
  input  lc_mode_e         mode_q,
  input  logic             init_ld,
  input  logic [DEPTH-1:0] init_bits,
  input  logic             ram_wr_evt,
  input  logic             lo_shift_evt,
  input  logic             hi_shift_evt,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       din,
  output logic [DEPTH-1:0] mem_q
);

  logic [DEPTH-1:0] mem_d;

  always_comb begin
    mem_d = mem_q;
    if (init_ld) begin
      mem_d = init_bits;
    end else if (ram_wr_evt) begin
      mem_d[sel] = din[0];
    end else begin
      if (lo_shift_evt) begin
        if (lc_is_split(mode_q))
          mem_d[QUARTER-1:0] = {mem_q[QUARTER-2:0], din[0]};
        else
          mem_d[HALF-1:0] = {mem_q[HALF-2:0], din[0]};
      end
      if (hi_shift_evt)
        mem_d[HALF-1:QUARTER] = {mem_q[HALF-2:QUARTER], din[1]};
    end
  end

  always_ff @(posedge clk) mem_q <= mem_d;

endmodule

// File: rtl/lcell_read.sv
module lcell_read
  import lcell_pkg::*;
#(
  parameter int SEL_W = 6,
  localparam int DEPTH   = 1 << SEL_W,
  localparam int HALF    = DEPTH / 2,
  localparam int QUARTER = DEPTH / 4
) (
  input  lc_mode_e         mode_q,
  input  logic [DEPTH-1:0] mem_q,
  input  logic [SEL_W-1:0] sel,
  output logic [1:0]       o,
  output logic [1:0]       cas_o
);

  logic [SEL_W-1:0] idx_lo5, idx_hi5, idx_lo4, idx_hi4;

  assign idx_lo5 = {1'b0, sel[SEL_W-2:0]};
  assign idx_hi5 = {1'b1, sel[SEL_W-2:0]};
  assign idx_lo4 = {2'b00, sel[SEL_W-3:0]};
  assign idx_hi4 = {2'b01, sel[SEL_W-3:0]};

  always_comb begin
    o     = '0;
    cas_o = '0;
    case (mode_q)
      LC_LUT5X2: begin
        o[0] = mem_q[idx_lo5];
        o[1] = mem_q[idx_hi5];
      end
      LC_RAM: o[0] = mem_q[sel];
      LC_SRL32: begin
        o[0]     = mem_q[idx_lo5];
        cas_o[0] = mem_q[HALF-1];
      end
      LC_SRL16X2: begin
        o[0]  = mem_q[idx_lo4];
        o[1]  = mem_q[idx_hi4];
        cas_o = {mem_q[HALF-1], mem_q[QUARTER-1]};
      end
      default: o[0] = mem_q[sel];
    endcase
  end

endmodule

// File: rtl/lcell_oreg.sv
module lcell_oreg #(
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ff_ce,
  input  logic             ff_srst,
  input  logic [N_OUT-1:0] d,
  output logic [N_OUT-1:0] q
);

  for (genvar i = 0; i < N_OUT; i++) begin : g_ff
    always_ff @(posedge clk) begin
      if (rst || ff_srst) q[i] <= 1'b0;
      else if (ff_ce)     q[i] <= d[i];
    end
  end

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import lcell_pkg::*;
#(
  parameter int SEL_W = 6,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_ld,
  input  logic [DEPTH-1:0] init_bits,
  input  logic             mode_ld,
  input  logic [2:0]       mode_in,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       din,
  input  logic             we,
  input  logic [1:0]       sh_en,
  input  logic             ff_ce,
  input  logic             ff_srst,
  output logic [1:0]       o,
  output logic [1:0]       q,
  output logic [1:0]       cas_o
);

  lc_mode_e         mode_q;
  logic [DEPTH-1:0] mem_q;
  logic             ram_wr_evt;
  logic             lo_shift_evt;
  logic             hi_shift_evt;

  lcell_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode_ld(mode_ld), .init_ld(init_ld),
    .mode_in(mode_in), .we(we), .sh_en(sh_en), .mode_q(mode_q),
    .ram_wr_evt(ram_wr_evt), .lo_shift_evt(lo_shift_evt),
    .hi_shift_evt(hi_shift_evt)
  );

  lcell_store #(.SEL_W(SEL_W)) u_store (
    .clk(clk), .mode_q(mode_q), .init_ld(init_ld), .init_bits(init_bits),
    .ram_wr_evt(ram_wr_evt), .lo_shift_evt(lo_shift_evt),
    .hi_shift_evt(hi_shift_evt), .sel(sel), .din(din), .mem_q(mem_q)
  );

  lcell_read #(.SEL_W(SEL_W)) u_read (
    .mode_q(mode_q), .mem_q(mem_q), .sel(sel), .o(o), .cas_o(cas_o)
  );

  lcell_oreg #(.N_OUT(2)) u_oreg (
    .clk(clk), .rst(rst), .ff_ce(ff_ce), .ff_srst(ff_srst), .d(o), .q(q)
  );

endmodule

// File: rtl/lcell_chk.sv
module lcell_chk
  import lcell_pkg::*;
#(
  parameter int SEL_W = 6,
  localparam int DEPTH   = 1 << SEL_W,
  localparam int HALF    = DEPTH / 2,
  localparam int QUARTER = DEPTH / 4
) (
  input logic             clk,
  input logic             rst,
  input logic             init_ld,
  input logic [DEPTH-1:0] init_bits,
  input logic             mode_ld,
  input logic [2:0]       mode_in,
  input logic [SEL_W-1:0] sel,
  input logic [1:0]       din,
  input logic             ff_ce,
  input logic             ff_srst,
  input logic [1:0]       o,
  input logic [1:0]       q,
  input lc_mode_e         mode_q,
  input logic [DEPTH-1:0] mem_q,
  input logic             ram_wr_evt,
  input logic             lo_shift_evt,
  input logic             hi_shift_evt
);

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (rst)
    init_ld |=> mem_q == $past(init_bits)); // R1
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
    mode_ld |=> mode_q == lc_mode_e'($past(mode_in))); // R1
  AST_LOAD_BLOCKS_OPS: assert property (@(posedge clk) disable iff (rst)
    (init_ld || mode_ld) |-> !(ram_wr_evt || lo_shift_evt || hi_shift_evt)); // R1
  AST_RAM_WRITE: assert property (@(posedge clk) disable iff (rst)
    ram_wr_evt |=> mem_q[$past(sel)] == $past(din[0])); // R4
  AST_SHIFT32_STEP: assert property (@(posedge clk) disable iff (rst)
    (lo_shift_evt && mode_q == LC_SRL32) |=>
      mem_q[HALF-1:0] == {$past(mem_q[HALF-2:0]), $past(din[0])}); // R5
  AST_SPLIT_HI_STEP: assert property (@(posedge clk) disable iff (rst)
    hi_shift_evt |=>
      mem_q[HALF-1:QUARTER] == {$past(mem_q[HALF-2:QUARTER]), $past(din[1])}); // R6
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (rst)
    ram_wr_evt |-> mode_q == LC_RAM); // R7
  AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (rst)
    (lo_shift_evt || hi_shift_evt) |-> (mode_q == LC_SRL32 || mode_q == LC_SRL16X2)); // R7
  AST_MODE_ONLY_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (mode_ld && !init_ld) |=> $stable(mem_q)); // R8
  AST_Q_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (ff_ce && !ff_srst) |=> q == $past(o)); // R9
  AST_Q_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ff_srst |=> q == 2'b00); // R9
  AST_Q_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ff_ce && !ff_srst) |=> $stable(q)); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (mode_q == LC_LUT6 && q == 2'b00)); // R10

endmodule

bind cfg_logic_cell lcell_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .init_ld(init_ld), .init_bits(init_bits),
  .mode_ld(mode_ld), .mode_in(mode_in), .sel(sel), .din(din),
  .ff_ce(ff_ce), .ff_srst(ff_srst), .o(o), .q(q), .mode_q(mode_q),
  .mem_q(mem_q), .ram_wr_evt(ram_wr_evt), .lo_shift_evt(lo_shift_evt),
  .hi_shift_evt(hi_shift_evt)
);

// File: tb/cfg_logic_cell_test.sv
module cfg_logic_cell_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_ld = 1'b0;
  logic [63:0] init_bits = '0;
  logic        mode_ld = 1'b0;
  logic [2:0]  mode_in = '0;
  logic [5:0]  sel = '0;
  logic [1:0]  din = '0;
  logic        we = 1'b0;
  logic [1:0]  sh_en = '0;
  logic        ff_ce = 1'b0;
  logic        ff_srst = 1'b0;
  logic [1:0]  o, q, cas_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [63:0] PAT = 64'h0123_4567_89AB_CDEF;

  // {mode, sel, expected o} against PAT
  localparam logic [10:0] VEC [12] = '{
    {3'd0, 6'd0,  2'b01}, {3'd0, 6'd5,  2'b01}, {3'd0, 6'd4,  2'b00},
    {3'd0, 6'd63, 2'b00}, {3'd0, 6'd40, 2'b01}, {3'd1, 6'd0,  2'b11},
    {3'd1, 6'd35, 2'b01}, {3'd1, 6'd3,  2'b01}, {3'd1, 6'd31, 2'b01},
    {3'd1, 6'd18, 2'b00}, {3'd7, 6'd4,  2'b00}, {3'd5, 6'd0,  2'b01}
  };

  cfg_logic_cell uut (
    .clk(clk), .rst(rst), .init_ld(init_ld), .init_bits(init_bits),
    .mode_ld(mode_ld), .mode_in(mode_in), .sel(sel), .din(din), .we(we),
    .sh_en(sh_en), .ff_ce(ff_ce), .ff_srst(ff_srst), .o(o), .q(q),
    .cas_o(cas_o)
  );

  always #10 clk = ~clk;

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    report();
  end

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_init(logic [63:0] b);
    init_ld = 1'b1; init_bits = b; step(); init_ld = 1'b0;
  endtask

  task automatic do_mode(logic [2:0] m);
    mode_ld = 1'b1; mode_in = m; step(); mode_ld = 1'b0;
  endtask

  task automatic do_shift(logic [1:0] en, logic [1:0] d);
    sh_en = en; din = d; step(); sh_en = 2'b00;
  endtask

  task automatic look(logic [5:0] s, string tag, logic [1:0] exp);
    sel = s; #1; check(tag, o, exp);
  endtask

  initial begin
    step(); step(); step();
    check("R10 reset q", q, 2'b00);
    check("R10 reset cas", cas_o, 2'b00);
    rst = 1'b0;
    do_init(PAT);

    // table walk: R2 / R3 / R11 reads, R8 mode-only loads, R9 capture
    for (int i = 0; i < 12; i++) begin
      string tag;
      do_mode(VEC[i][10:8]);
      tag = (VEC[i][10:8] == 3'd1) ? "R3" : (VEC[i][10:8] == 3'd0) ? "R2" : "R11";
      look(VEC[i][7:2], $sformatf("%s vec%0d", tag, i), VEC[i][1:0]);
      ff_ce = 1'b1; step(); ff_ce = 1'b0; #1;
      check($sformatf("R9 capture vec%0d", i), q, VEC[i][1:0]);
    end

    // R8: mode-only loads keep contents
    do_mode(3'd2); do_mode(3'd0);
    look(6'd5, "R8 contents kept", 2'b01);

    // R9: hold and clear
    look(6'd0, "R2 sel0", 2'b01);
    ff_ce = 1'b1; step(); ff_ce = 1'b0;
    sel = 6'd4; step(); #1;
    check("R9 hold", q, 2'b01);
    sel = 6'd0; ff_ce = 1'b1; ff_srst = 1'b1; step(); ff_ce = 1'b0; ff_srst = 1'b0; #1;
    check("R9 clear beats enable", q, 2'b00);

    // R10: reset returns mode 0, keeps contents
    ff_ce = 1'b1; step(); ff_ce = 1'b0;
    do_mode(3'd1);
    rst = 1'b1; step(); rst = 1'b0; #1;
    check("R10 q cleared", q, 2'b00);
    look(6'd32, "R10 mode0 and contents", 2'b01);

    // R4: RAM
    do_init(64'd0); do_mode(3'd2);
    sel = 6'd10; din = 2'b01; we = 1'b1; step(); we = 1'b0;
    look(6'd10, "R4 write one", 2'b01);
    look(6'd11, "R4 neighbour", 2'b00);
    sel = 6'd10; din = 2'b00; we = 1'b1; step(); we = 1'b0;
    look(6'd10, "R4 write zero", 2'b00);
    // R1: load beats write
    sel = 6'd0; din = 2'b00; we = 1'b1; do_init({64{1'b1}}); we = 1'b0;
    look(6'd0, "R1 load beats write", 2'b01);

    // R7: stray enables
    do_mode(3'd0); do_init(64'd0);
    sel = 6'd3; din = 2'b01; we = 1'b1; step(); we = 1'b0;
    look(6'd3, "R7 we ignored", 2'b00);
    do_shift(2'b11, 2'b11);
    look(6'd0, "R7 shift ignored", 2'b00);

    // R5: 32-stage chain
    do_init(64'hFFFF_FFFF_0000_0000); do_mode(3'd3);
    do_shift(2'b01, 2'b01);
    look(6'd0, "R5 first stage", 2'b01);
    check("R5 cas empty", cas_o, 2'b00);
    for (int k = 0; k < 31; k++) do_shift(2'b01, 2'b00);
    look(6'd31, "R5 last tap", 2'b01);
    look(6'd63, "R5 sel5 ignored", 2'b01);
    check("R5 cas full", cas_o, 2'b01);
    do_shift(2'b01, 2'b00);
    check("R5 cas drop", cas_o, 2'b00);
    do_mode(3'd0);
    look(6'd32, "R5 upper half kept", 2'b01);
    look(6'd31, "R5 bit dropped", 2'b00);
    check("R10 cas zero outside shift", cas_o, 2'b00);

    // R6: split chains
    do_init(64'd0); do_mode(3'd4);
    do_shift(2'b01, 2'b01);
    look(6'd0, "R6 low chain only", 2'b01);
    do_shift(2'b10, 2'b10);
    look(6'd0, "R6 high chain", 2'b11);
    for (int k = 0; k < 15; k++) do_shift(2'b01, 2'b00);
    check("R6 low cas", cas_o, 2'b01);
    look(6'd15, "R6 taps at end", 2'b01);
    do_shift(2'b01, 2'b00);
    check("R6 low drop", cas_o, 2'b00);
    look(6'd0, "R6 independence", 2'b10);
    for (int k = 0; k < 15; k++) do_shift(2'b10, 2'b00);
    check("R6 high cas", cas_o, 2'b10);

    report();
  end

endmodule